// File: doc/BRIEF.md
# Single-Cell Charger Sequencing Controller

This block is the digital sequencer of a linear single-cell lithium charger. It takes the input-good flags of the adapter and USB sources, the active-low charge enable and the battery comparator flags. From them it decides whether the charge path is on, which current level the analog loop is asked for, and whether the active-low charging indicator is pulled. The sequencer has six one-hot states: power-off, disabled, trickle, fast charge at the adapter level, fast charge at the USB level, and charge complete. When both sources are good, the adapter is the selected source. The analog side turns each current code into a real current. The trickle code stands for a fixed fraction, about 18%, of the programmed level.

End-of-charge is reached when the battery sits at its regulation voltage and the current stays below the termination level for a parameterised run of consecutive cycles. The same debounce covers the case where the programmed current is already under the termination level. At end-of-charge only the indicator is released. The charge path stays on at the level of the source that was selected when the state was entered. The complete status is latched and clears on one of three events: a disable and re-enable, a change of the selected source, or the battery dropping below the recharge threshold.

Top module: `chg_seq_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `chg_on`=0, `cur_mode`=2'b00 and `chg_n`=1. These are the power-off outputs.
- R2: When neither `adp_ok` nor `usb_ok` is high, the outputs go to the power-off values after the next clock edge, whatever the state.
- R3: With at least one source good and `en_n` high, the next outputs are `chg_on`=0, `cur_mode`=2'b00 and `chg_n`=1 (disabled).
- R4: With a source good, `en_n` low and `bat_below_min` high, the block enters trickle. The outputs are `chg_on`=1, `cur_mode`=2'b01 and `chg_n`=0.
- R5: With a source good, `en_n` low and the battery above the minimum, the block fast-charges. `cur_mode` is 2'b11 (adapter level) when `adp_ok` is high, even if USB is also good, and 2'b10 (USB level) when only `usb_ok` is high. `chg_n` is 0.
- R6: If the adapter drops during adapter fast charge while USB stays good, the next outputs are USB-level fast charge.
- R7: In fast charge, if `bat_at_reg` and `i_below_term` are both high at EOC_DEB consecutive clock edges, the block enters charge complete after the last of those edges. In that state `chg_n`=1, `chg_on`=1 and `cur_mode` keeps the source level.
- R8: A single cycle in which the termination condition is false restarts the debounce count from zero.
- R9: Charge complete is latched. It holds when `bat_at_reg` or `i_below_term` later drop.
- R10: Charge complete clears when `bat_below_rch` is high, and fast charge (or trickle) resumes on the next edge.
- R11: Charge complete clears when the selected source changes, for example when the adapter is removed while USB is good. The source coming back then gives fast charge, not complete.
- R12: Charge complete clears on a disable and re-enable through `en_n`.
- R13: The state register is one-hot. Every output is registered and responds to an input change on the first clock edge after it. `chg_n` low always implies `chg_on` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Charge enable, active low |
| adp_ok | input | 1 | Adapter input valid (above power-on, below overvoltage, above battery) |
| usb_ok | input | 1 | USB input valid |
| bat_below_min | input | 1 | Battery below the trickle threshold |
| bat_below_rch | input | 1 | Battery below the recharge threshold |
| bat_at_reg | input | 1 | Battery at the regulation voltage |
| i_below_term | input | 1 | Charge current below the termination level |
| chg_on | output | 1 | Charge path enable |
| cur_mode | output | 2 | Current request: 00 none, 01 trickle, 10 USB level, 11 adapter level |
| chg_n | output | 1 | Charging indicator, active low |

## Verification
Every output is registered from the next-state decode. A change driven on a falling edge is therefore visible after the next rising edge, and every check samples on the following falling edge. End-of-charge is due exactly after the EOC_DEB-th rising edge at which the termination condition holds. The bench sets EOC_DEB to 4 and checks the indicator both one edge before that point and at it, so an early or late transition is caught. The restart case drops the condition for one cycle and repeats the same count.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [5:0] {
    S_OFF  = 6'b000001,
    S_DIS  = 6'b000010,
    S_TRK  = 6'b000100,
    S_FADP = 6'b001000,
    S_FUSB = 6'b010000,
    S_DONE = 6'b100000
  } chg_st_t;

  typedef enum logic [1:0] {
    M_NONE = 2'b00,
    M_TRK  = 2'b01,
    M_USB  = 2'b10,
    M_ADP  = 2'b11
  } chg_mode_t;

endpackage

// File: rtl/chg_eoc_filter.sv
module chg_eoc_filter #(
  parameter int EOC_DEB = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cond,
  output logic hit
);
  localparam int CW = (EOC_DEB > 1) ? $clog2(EOC_DEB) : 1;
  localparam logic [CW-1:0] LAST = CW'(EOC_DEB - 1);

  logic [CW-1:0] cnt_q;
  logic          run;

  assign run = arm & cond;
  assign hit = run & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_state_core.sv
module chg_state_core
  import chg_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en_n,
  input  logic    adp_ok,
  input  logic    usb_ok,
  input  logic    bat_below_min,
  input  logic    bat_below_rch,
  input  logic    eoc_hit,
  output logic    eoc_arm,
  output chg_st_t st_q,
  output chg_st_t st_d,
  output logic    done_adp_d
);
  logic sel_adp;
  logic done_adp_q;
  logic keep_done;

  assign sel_adp = adp_ok;
  assign eoc_arm = ((st_q == S_FADP) &&  sel_adp) ||
                   ((st_q == S_FUSB) && !sel_adp && usb_ok);
  assign keep_done = (st_q == S_DONE) && !bat_below_rch &&
                     (done_adp_q == sel_adp);

  always_comb begin
    done_adp_d = done_adp_q;
    if (!adp_ok && !usb_ok)   st_d = S_OFF;
    else if (en_n)            st_d = S_DIS;
    else if (keep_done)       st_d = S_DONE;
    else if (bat_below_min)   st_d = S_TRK;
    else if (eoc_hit) begin
      st_d       = S_DONE;
      done_adp_d = sel_adp;
    end
    else if (sel_adp)         st_d = S_FADP;
    else                      st_d = S_FUSB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_OFF;
      done_adp_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      done_adp_q <= done_adp_d;
    end
  end
endmodule

// File: rtl/chg_out_reg.sv
module chg_out_reg
  import chg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  chg_st_t   st_d,
  input  logic      done_adp_d,
  output logic      chg_on,
  output chg_mode_t cur_mode,
  output logic      chg_n
);
  chg_mode_t mode_d;
  logic      on_d;
  logic      ind_d;

  always_comb begin
    unique case (st_d)
      S_TRK:   mode_d = M_TRK;
      S_FADP:  mode_d = M_ADP;
      S_FUSB:  mode_d = M_USB;
      S_DONE:  mode_d = done_adp_d ? M_ADP : M_USB;
      default: mode_d = M_NONE;
    endcase
    on_d  = (st_d == S_TRK) || (st_d == S_FADP) ||
            (st_d == S_FUSB) || (st_d == S_DONE);
    ind_d = (st_d == S_TRK) || (st_d == S_FADP) || (st_d == S_FUSB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_on   <= 1'b0;
      cur_mode <= M_NONE;
      chg_n    <= 1'b1;
    end else begin
      chg_on   <= on_d;
      cur_mode <= mode_d;
      chg_n    <= ~ind_d;
    end
  end
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_seq_pkg::*;
#(
  parameter int EOC_DEB = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_n,
  input  logic       adp_ok,
  input  logic       usb_ok,
  input  logic       bat_below_min,
  input  logic       bat_below_rch,
  input  logic       bat_at_reg,
  input  logic       i_below_term,
  output logic       chg_on,
  output logic [1:0] cur_mode,
  output logic       chg_n
);
  chg_st_t   st_q;
  chg_st_t   st_d;
  chg_mode_t mode_q;
  logic      done_adp_d;
  logic      eoc_arm;
  logic      eoc_hit;

  chg_eoc_filter #(.EOC_DEB(EOC_DEB)) u_eoc (
    .clk  (clk),
    .rst  (rst),
    .arm  (eoc_arm),
    .cond (bat_at_reg & i_below_term),
    .hit  (eoc_hit)
  );

  chg_state_core u_core (
    .clk           (clk),
    .rst           (rst),
    .en_n          (en_n),
    .adp_ok        (adp_ok),
    .usb_ok        (usb_ok),
    .bat_below_min (bat_below_min),
    .bat_below_rch (bat_below_rch),
    .eoc_hit       (eoc_hit),
    .eoc_arm       (eoc_arm),
    .st_q          (st_q),
    .st_d          (st_d),
    .done_adp_d    (done_adp_d)
  );

  chg_out_reg u_out (
    .clk        (clk),
    .rst        (rst),
    .st_d       (st_d),
    .done_adp_d (done_adp_d),
    .chg_on     (chg_on),
    .cur_mode   (mode_q),
    .chg_n      (chg_n)
  );

  assign cur_mode = mode_q;
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_n,
  input logic       adp_ok,
  input logic       usb_ok,
  input logic       bat_below_min,
  input logic       bat_below_rch,
  input logic       chg_on,
  input logic [1:0] cur_mode,
  input logic       chg_n,
  input logic [5:0] st
);
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> (!chg_on && cur_mode == 2'b00 && chg_n));

  a_r2_no_input_off: assert property (@(posedge clk) disable iff (rst)
    (!adp_ok && !usb_ok) |=> (!chg_on && cur_mode == 2'b00 && chg_n));

  a_r3_disable: assert property (@(posedge clk) disable iff (rst)
    (en_n && (adp_ok || usb_ok)) |=> (!chg_on && chg_n));

  a_r4_trickle: assert property (@(posedge clk) disable iff (rst)
    (!en_n && (adp_ok || usb_ok) && bat_below_min && bat_below_rch)
      |=> (cur_mode == 2'b01 && !chg_n));

  a_r7_done_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (chg_on && chg_n) |-> cur_mode[1]);

  a_r13_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(st));

  a_r13_ind_implies_on: assert property (@(posedge clk) disable iff (rst)
    !chg_n |-> chg_on);
endmodule

bind chg_seq_top chg_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .en_n          (en_n),
  .adp_ok        (adp_ok),
  .usb_ok        (usb_ok),
  .bat_below_min (bat_below_min),
  .bat_below_rch (bat_below_rch),
  .chg_on        (chg_on),
  .cur_mode      (cur_mode),
  .chg_n         (chg_n),
  .st            (st_q)
);

// File: tb/tb_chg_seq_top.sv
module tb_chg_seq_top;
  localparam int DEB = 4;
  localparam int NV  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1, adp_ok = 1'b0, usb_ok = 1'b0;
  logic bmin = 1'b1, brch = 1'b1, breg = 1'b0, bterm = 1'b0;
  logic       chg_on;
  logic [1:0] cur_mode;
  logic       chg_n;

  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  chg_seq_top #(.EOC_DEB(DEB)) dut (
    .clk(clk), .rst(rst), .en_n(en_n), .adp_ok(adp_ok), .usb_ok(usb_ok),
    .bat_below_min(bmin), .bat_below_rch(brch), .bat_at_reg(breg),
    .i_below_term(bterm), .chg_on(chg_on), .cur_mode(cur_mode), .chg_n(chg_n)
  );

  // {en_n, adp, usb, bmin, brch, breg, bterm, exp_on, exp_mode[1:0], exp_chg_n}
  localparam logic [10:0] VEC [NV] = '{
    11'b1_0_0_1_1_0_0_0_00_1,  // R2 no source
    11'b1_1_0_1_1_0_0_0_00_1,  // R3 disabled
    11'b0_1_0_1_1_0_0_1_01_0,  // R4 trickle
    11'b0_1_0_0_1_0_0_1_11_0,  // R5 adapter fast
    11'b0_1_1_0_1_0_0_1_11_0,  // R5 both good: adapter
    11'b0_0_1_0_1_0_0_1_10_0,  // R6 adapter lost
    11'b0_1_1_0_1_0_0_1_11_0,  // R5 adapter back
    11'b1_1_1_0_1_0_0_0_00_1,  // R3 disable
    11'b0_0_1_1_1_0_0_1_01_0,  // R4 trickle on USB
    11'b0_0_0_1_1_0_0_0_00_1,  // R2 all removed
    11'b0_0_1_0_0_0_0_1_10_0   // R5 USB fast
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic e, a, u, mn, rc, rg, tm);
    en_n = e; adp_ok = a; usb_ok = u; bmin = mn; brch = rc; breg = rg; bterm = tm;
  endtask

  task automatic chk(input string req, input logic on, input logic [1:0] md, input logic cn);
    checks++;
    if (chg_on !== on || cur_mode !== md || chg_n !== cn) begin
      errors++;
      $display("FAIL %s: got on=%b mode=%b chg_n=%b, expected on=%b mode=%b chg_n=%b",
               req, chg_on, cur_mode, chg_n, on, md, cn);
    end
  endtask

  // put the block in adapter-level complete (R7 path), starting from adapter fast charge
  task automatic reach_done_adp();
    drive(0, 1, 1, 0, 0, 0, 0); tick();
    drive(0, 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < DEB; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    chk("R1 during reset", 0, 2'b00, 1);
    drive(0, 1, 1, 0, 0, 0, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R13: one edge after releasing reset with a source good, fast charge appears
    chk("R13 one-edge latency", 1, 2'b11, 0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      tick();
      chk($sformatf("vector %0d (R2-R6)", v), VEC[v][3], VEC[v][2:1], VEC[v][0]);
    end

    // R7: exact debounce point
    drive(0, 1, 1, 0, 0, 0, 0); tick();
    drive(0, 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < DEB - 1; i++) tick();
    chk("R7 not yet complete", 1, 2'b11, 0);
    tick();
    chk("R7 complete", 1, 2'b11, 1);

    // R9: latched while condition goes away
    drive(0, 1, 1, 0, 0, 0, 0); tick(); tick();
    chk("R9 latched", 1, 2'b11, 1);

    // R10: recharge threshold clears
    drive(0, 1, 1, 0, 1, 0, 0); tick();
    chk("R10 recharge", 1, 2'b11, 0);
    drive(0, 1, 1, 0, 0, 0, 0); tick();
    chk("R10 stays fast", 1, 2'b11, 0);

    // R8: restart on one-cycle drop
    drive(0, 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < DEB - 1; i++) tick();
    drive(0, 1, 1, 0, 0, 1, 0); tick();
    drive(0, 1, 1, 0, 0, 1, 1);
    for (int i = 0; i < DEB - 1; i++) tick();
    chk("R8 count restarted", 1, 2'b11, 0);
    tick();
    chk("R8 complete after full run", 1, 2'b11, 1);

    // R11: source change clears, reapply does not restore complete
    drive(0, 0, 1, 0, 0, 0, 0); tick();
    chk("R11 adapter removed", 1, 2'b10, 0);
    drive(0, 1, 1, 0, 0, 0, 0); tick();
    chk("R11 adapter reapplied", 1, 2'b11, 0);

    // R12: disable and re-enable clears
    reach_done_adp();
    chk("R12 complete before disable", 1, 2'b11, 1);
    drive(1, 1, 1, 0, 0, 0, 0); tick();
    chk("R12 disabled", 0, 2'b00, 1);
    drive(0, 1, 1, 0, 0, 0, 0); tick();
    chk("R12 re-enabled fast", 1, 2'b11, 0);

    // R2 from complete
    reach_done_adp();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    chk("R2 off from complete", 0, 2'b00, 1);

    // R1: reset in mid-charge
    drive(0, 1, 0, 0, 0, 0, 0); tick();
    rst = 1'b1; tick();
    chk("R1 mid-run reset", 0, 2'b00, 1);
    rst = 1'b0;

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule